// File: doc/BRIEF.md
# Color Lookup Palette Memory

This block is the color lookup table of a display controller. It holds 128 words of 32 bits, and each word carries two 16-bit color entries, so there are 256 palette indices. A register bus reaches the memory through a 512-byte window that starts at byte offset 0x200. It stores whole words and returns them unchanged on a read.

A separate lookup port serves the pixel pipeline. The port accepts an 8-bit palette index on a valid/ready request channel. It returns a 24-bit RGB value on a valid/ready response channel. Each color entry packs three 5-bit components and an intensity flag. The block drops the flag and widens each component to 8 bits by appending three zero bits.

The response side is a single output register. A request is accepted whenever that register is empty or is being drained in the same cycle, so `req_ready = !rsp_valid || rsp_ready`. While the consumer holds `rsp_ready` low, the response stays frozen and no new request is taken.

Top module: `clut_palette`

## Requirements
- R1: A bus write (`bus_en`=1, `bus_we`=1) to byte offset A with 0x200 <= A <= 0x3FF stores `bus_wdata` in word (A-0x200)>>2, so the two low address bits are ignored. A bus read (`bus_en`=1, `bus_we`=0) of that word drives the exact stored value on `bus_rdata` in the cycle after the read is issued.
- R2: A bus access outside 0x200..0x3FF changes no palette word. A read there returns zero on `bus_rdata` in the following cycle.
- R3: After reset every word reads as zero, every lookup returns RGB zero, and `rsp_valid` is 0.
- R4: Palette index 2n selects bits [15:0] of word n, and index 2n+1 selects bits [31:16] of word n.
- R5: Within a selected entry, red is bits [4:0], green is bits [9:5] and blue is bits [14:10]. The output `rsp_rgb` carries red in [23:16], green in [15:8] and blue in [7:0]. Each output component equals its 5-bit field shifted left by three, so its three low bits are zero.
- R6: Bit 15 of an entry (the intensity flag) has no effect on `rsp_rgb`.
- R7: A request accepted at a clock edge (`req_valid` and `req_ready` both 1) makes `rsp_valid` 1 with its color from the following cycle. With no accept and no stall, `rsp_valid` returns to 0.
- R8: If a bus write and a lookup accept reach the same entry at the same edge, the lookup returns the entry's old value. Later lookups return the new value.
- R9: While `rsp_valid`=1 and `rsp_ready`=0, `req_ready` is 0, and `rsp_rgb` and `rsp_valid` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted when high |
| req_index | input | 8 | Palette index |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_ready | input | 1 | Consumer accepts the result |
| rsp_rgb | output | 24 | Expanded color {R,G,B} |

## Verification
The bench writes distinct patterns into both halves of one word. A design that swapped the halves, or that indexed the word with the full index instead of its upper seven bits, would return the wrong neighbour's color. It sets only the intensity flag, and then only single color fields, so a design that leaked bit 15 into blue or misplaced a field would show non-zero or shifted components. It issues a write and a lookup to the same entry in one cycle, and a read-after-write design would return the new color too early. It also stalls the response while a second request waits: a design that dropped or overwrote the held result would show a changed `rsp_rgb`, and one that accepted the waiting request early would lose it. Writes just outside the window must leave the first and last words untouched.

// File: rtl/clut_palette_pkg.sv
package clut_palette_pkg;
  localparam int unsigned COMP_IN_W  = 5;
  localparam int unsigned COMP_OUT_W = 8;
  localparam int unsigned PAD_W      = COMP_OUT_W - COMP_IN_W;
  localparam int unsigned N_COMP     = 3;

  typedef logic [COMP_IN_W-1:0]  comp_in_t;
  typedef logic [COMP_OUT_W-1:0] comp_out_t;

  function automatic comp_out_t widen(input comp_in_t c);
    return {c, {PAD_W{1'b0}}};
  endfunction
endpackage

// File: rtl/clut_store.sv
module clut_store #(
  parameter int unsigned WORDS = 128,
  parameter int unsigned DW    = 32,
  localparam int unsigned WA   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [WA-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [WA-1:0] rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [WA-1:0] rd_b_idx,
  output logic [DW-1:0] rd_b_data
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(WORDS); i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_a_data = mem[rd_a_idx];
  assign rd_b_data = mem[rd_b_idx];
endmodule

// File: rtl/clut_expand.sv
module clut_expand
  import clut_palette_pkg::*;
#(
  parameter int unsigned ENTRY_W = 16,
  localparam int unsigned RGB_W  = N_COMP * COMP_OUT_W
) (
  input  logic [ENTRY_W-1:0] entry,
  output logic [RGB_W-1:0]   rgb
);
  // component i sits at entry[i*5 +: 5]; output places red highest
  for (genvar i = 0; i < int'(N_COMP); i++) begin : g_comp
    assign rgb[(N_COMP-1-i)*COMP_OUT_W +: COMP_OUT_W] =
      widen(entry[i*COMP_IN_W +: COMP_IN_W]);
  end
endmodule

// File: rtl/clut_lookup.sv
module clut_lookup #(
  parameter int unsigned DW      = 32,
  parameter int unsigned ENTRY_W = 16,
  parameter int unsigned IDX_W   = 8,
  localparam int unsigned EPW    = DW / ENTRY_W,
  localparam int unsigned SEL_W  = $clog2(EPW)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [IDX_W-1:0]   req_index,
  input  logic [DW-1:0]      word_in,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [ENTRY_W-1:0] entry_q
);
  logic             accept;
  logic [SEL_W-1:0] sel;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign sel       = req_index[SEL_W-1:0];

  // entry captured at the accepting edge, before any same-edge write lands
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      entry_q   <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      entry_q   <= word_in[sel*ENTRY_W +: ENTRY_W];
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/clut_palette.sv
module clut_palette
  import clut_palette_pkg::*;
#(
  parameter int unsigned WORDS    = 128,
  parameter int unsigned DW       = 32,
  parameter int unsigned ENTRY_W  = 16,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned BASE_OFF = 32'h200,
  localparam int unsigned WA      = $clog2(WORDS),
  localparam int unsigned EPW     = DW / ENTRY_W,
  localparam int unsigned IDX_W   = $clog2(WORDS * EPW),
  localparam int unsigned SEL_W   = $clog2(EPW),
  localparam int unsigned BYTES_W = $clog2(DW / 8),
  localparam int unsigned LIMIT   = BASE_OFF + WORDS * (DW / 8),
  localparam int unsigned RGB_W   = N_COMP * COMP_OUT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_index,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [RGB_W-1:0]  rsp_rgb
);
  logic              hit;
  logic [ADDR_W-1:0] off;
  logic [WA-1:0]     bus_idx;
  logic [DW-1:0]     bus_word, lk_word;
  logic [ENTRY_W-1:0] entry_q;

  assign hit     = (32'(bus_addr) >= BASE_OFF) && (32'(bus_addr) < LIMIT);
  assign off     = bus_addr - ADDR_W'(BASE_OFF);
  assign bus_idx = off[BYTES_W +: WA];

  clut_store #(.WORDS(WORDS), .DW(DW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_en && bus_we && hit),
    .wr_idx   (bus_idx),
    .wr_data  (bus_wdata),
    .rd_a_idx (bus_idx),
    .rd_a_data(bus_word),
    .rd_b_idx (req_index[SEL_W +: WA]),
    .rd_b_data(lk_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                bus_rdata <= '0;
    else if (bus_en && !bus_we) bus_rdata <= hit ? bus_word : '0;
  end

  clut_lookup #(.DW(DW), .ENTRY_W(ENTRY_W), .IDX_W(IDX_W)) u_lookup (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_index(req_index),
    .word_in  (lk_word),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .entry_q  (entry_q)
  );

  clut_expand #(.ENTRY_W(ENTRY_W)) u_expand (
    .entry(entry_q),
    .rgb  (rsp_rgb)
  );
endmodule

// File: rtl/clut_palette_chk.sv
module clut_palette_chk #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned BASE_OFF = 32'h200,
  parameter int unsigned LIMIT    = 32'h400
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [23:0]       rsp_rgb
);
  logic outside;
  assign outside = (32'(bus_addr) < BASE_OFF) || (32'(bus_addr) >= LIMIT);

  p_oob_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en && !bus_we && outside |=> bus_rdata == 32'h0);

  p_pad_bits_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rgb[18:16] == 3'b0 && rsp_rgb[10:8] == 3'b0 && rsp_rgb[2:0] == 3'b0));

  p_accept_gives_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  p_idle_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) && rsp_ready |=> !rsp_valid);

  p_stall_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  p_stall_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rgb));
endmodule

bind clut_palette clut_palette_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_en   (bus_en),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_rgb  (rsp_rgb)
);

// File: tb/tb_clut_palette.sv
module tb_clut_palette;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        req_valid = 1'b0, req_ready;
  logic [7:0]  req_index = '0;
  logic        rsp_valid, rsp_ready = 1'b1;
  logic [23:0] rsp_rgb;

  int n_tests = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  clut_palette dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] color(input logic [15:0] e);
    return {e[4:0], 3'b0, e[9:5], 3'b0, e[14:10], 3'b0};
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_en = 0; d = bus_rdata;
  endtask

  task automatic look(input logic [7:0] idx, output logic [23:0] rgb, output logic v);
    @(negedge clk); req_valid = 1; req_index = idx; rsp_ready = 1;
    @(negedge clk); req_valid = 0; rgb = rsp_rgb; v = rsp_valid;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic [23:0] c; logic v;
    check("R3 rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
    rd(12'h200, d); check("R3 word0 zero", d, 32'h0);
    rd(12'h3FC, d); check("R3 word127 zero", d, 32'h0);
    look(8'd255, c, v); check("R3 lookup zero", {8'h0, c}, 32'h0);
    @(negedge clk); check("R7 valid drops when idle", {31'b0, rsp_valid}, 32'h0);
  endtask

  task automatic t_bus();
    logic [31:0] d;
    wr(12'h204, 32'hDEADBEEF); rd(12'h204, d); check("R1 readback", d, 32'hDEADBEEF);
    wr(12'h3FF, 32'h12345678); rd(12'h3FC, d); check("R1 low addr bits ignored", d, 32'h12345678);
    wr(12'h1FC, 32'hFFFFFFFF); wr(12'h400, 32'hFFFFFFFF);
    rd(12'h200, d); check("R2 word0 untouched", d, 32'h0);
    rd(12'h3FC, d); check("R2 word127 untouched", d, 32'h12345678);
    rd(12'h1FC, d); check("R2 outside read zero", d, 32'h0);
    rd(12'h400, d); check("R2 outside read zero hi", d, 32'h0);
  endtask

  task automatic t_halves();
    logic [23:0] c; logic v;
    wr(12'h20C, {16'h7C00, 16'h001F});  // word 3: high blue only, low red only
    look(8'd6, c, v);
    check("R4 low half idx6", {8'h0, c}, {8'h0, color(16'h001F)});
    check("R7 valid next cycle", {31'b0, v}, 32'h1);
    look(8'd7, c, v); check("R4 high half idx7", {8'h0, c}, {8'h0, color(16'h7C00)});
    check("R5 blue placement", {8'h0, c}, 32'h000000F8);
    wr(12'h210, {16'h03E0, 16'h8000});  // word 4
    look(8'd9, c, v); check("R5 green placement", {8'h0, c}, 32'h0000F800);
    look(8'd8, c, v); check("R6 intensity ignored", {8'h0, c}, 32'h0);
    wr(12'h214, {16'hFFFF, 16'h5A5A});
    look(8'd11, c, v); check("R6 all ones", {8'h0, c}, 32'h00F8F8F8);
    look(8'd10, c, v); check("R5 mixed", {8'h0, c}, {8'h0, color(16'h5A5A)});
  endtask

  task automatic t_collide();
    logic [23:0] c; logic v;
    wr(12'h220, 32'h0000_0001);  // word 8, idx 16
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = 12'h220; bus_wdata = 32'h0000_0002;
    req_valid = 1; req_index = 8'd16; rsp_ready = 1;
    @(negedge clk);
    bus_en = 0; bus_we = 0; req_valid = 0;
    check("R8 same-edge returns old", {8'h0, rsp_rgb}, {8'h0, color(16'h0001)});
    look(8'd16, c, v); check("R8 later sees new", {8'h0, c}, {8'h0, color(16'h0002)});
  endtask

  task automatic t_stall();
    wr(12'h240, {16'h001F, 16'h03E0});  // word 16: idx32 green, idx33 red
    @(negedge clk); req_valid = 1; req_index = 8'd32; rsp_ready = 0;
    @(negedge clk); req_index = 8'd33;
    check("R9 ready low in stall", {31'b0, req_ready}, 32'h0);
    check("R9 first held", {8'h0, rsp_rgb}, 32'h0000F800);
    @(negedge clk);
    check("R9 still held", {8'h0, rsp_rgb}, 32'h0000F800);
    check("R9 valid held", {31'b0, rsp_valid}, 32'h1);
    rsp_ready = 1;
    @(negedge clk); req_valid = 0;
    check("R9 waiting request served", {8'h0, rsp_rgb}, 32'h00F80000);
    check("R7 valid after drain accept", {31'b0, rsp_valid}, 32'h1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_bus();
    t_halves();
    t_collide();
    t_stall();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule